// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block paces one analog-to-digital conversion on a successive-approximation converter. A one-cycle start strobe launches a conversion. The block then divides the system clock down to a converter clock and counts converter-clock cycles through three stretches. First comes a fixed settling overhead. Then a sampling window of programmable length follows, and then a fixed-length conversion window. The sample-and-convert pair can repeat for hardware averaging.

At the close of every conversion window the block takes the word presented by the converter. It masks that word to the selected resolution and adds it to an accumulator. After the last repetition it publishes the mean and raises a completion pulse. The configuration fields are captured when the strobe is accepted, so software may rewrite them freely while a conversion runs.

There is no back-pressure at either edge. The converter word is taken without a handshake at the cycle described in R7. The averaged result is a plain held register whose arrival is marked by the one-cycle completion pulse.

Top module: `sar_conv_sequencer`

## Requirements
- R1: The converter clock advances once every D system cycles. D = 2^clk_div multiplied by 2 when clk_src equals 01; any other clk_src value adds no division, so D ranges from 1 to 16.
- R2: A conversion accepted at edge E lasts T = 6 + N×(25 + L) converter cycles. `busy` is high from E until the T-th converter tick. `done` is high for exactly one system cycle, in the cycle that follows the edge T×D cycles after E.
- R3: The sampling length L is set by long_smp and smp_time. With long_smp = 0, the smp_time codes 00, 01, 10 and 11 give L = 3, 5, 7 and 9. With long_smp = 1, the same codes give L = 13, 17, 21 and 25.
- R4: The repetition count N is 1 while avg_en = 0. While avg_en = 1, the avg_num codes 00, 01, 10 and 11 give N = 4, 8, 16 and 32.
- R5: During the first 6 converter cycles of a conversion, `sample_ph` and `convert_ph` are both low. Each repetition then holds `sample_ph` high for L converter cycles, followed by `convert_ph` high for 25. Both are low while idle.
- R6: res_mode 00 keeps the low 8 bits of each converter word, 01 keeps the low 10 bits, and 10 or 11 keep all 12 bits. Masked-off bits contribute zero.
- R7: The converter word is taken on the edge that ends each conversion window. `result` equals the sum of the N masked words shifted right by log2(N). It updates together with `done` and holds until the next `done`.
- R8: Configuration is captured only when a start is accepted. Field changes during a conversion do not alter its length or result. A start strobe raised while `busy` is high is ignored and is not remembered.
- R9: After reset, `busy`, `done`, `sample_ph`, `convert_ph` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch strobe, accepted only while idle |
| cfg_clk_div | input | 2 | Converter clock divide exponent (1, 2, 4, 8) |
| cfg_clk_src | input | 2 | Clock source code; 01 adds a divide by 2 |
| cfg_long_smp | input | 1 | Selects the long group of sampling lengths |
| cfg_smp_time | input | 2 | Sampling length code within the group |
| cfg_avg_en | input | 1 | Enables hardware averaging |
| cfg_avg_num | input | 2 | Averaging count code (4, 8, 16, 32) |
| cfg_res_mode | input | 2 | Resolution code (8, 10, 12 bits) |
| adc_data | input | 12 | Word from the converter |
| busy | output | 1 | Conversion in progress |
| sample_ph | output | 1 | Sampling window active |
| convert_ph | output | 1 | Conversion window active |
| result | output | 12 | Averaged, masked result |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every timing fact is tied to the start edge E. The converter tick lands on edge E + k×D. The phase outputs change only on those edges, the converter word is taken at E + (6 + j×(25+L))×D for j = 1..N, and `done` with its `result` appears after edge E + T×D. The bench model counts edges since E at each rising edge and derives the expected phase, busy, done and result from that count. All outputs are compared at the falling edge, after every register on the path has settled. Separate start-to-done cycle counts and fixed-data results cross-check the formulas, including changes to the configuration in the middle of a conversion.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;

  typedef struct packed {
    logic [1:0] div;
    logic [1:0] src;
    logic       long_en;
    logic [1:0] sts;
    logic       avg_en;
    logic [1:0] avg_num;
    logic [1:0] res;
  } seq_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_OVH, ST_SMP, ST_CNV} seq_state_t;

  // sampling-window length: short group 3..9 step 2, long group 13..25 step 4
  function automatic logic [4:0] adder_cycles(input logic long_en, input logic [1:0] sts);
    logic [4:0] s;
    s = {3'b000, sts};
    return long_en ? (5'd13 + (s << 2)) : (5'd3 + (s << 1));
  endfunction

  // log2 of the repetition count
  function automatic logic [2:0] avg_shift(input logic en, input logic [1:0] num);
    return en ? (3'd2 + {1'b0, num}) : 3'd0;
  endfunction

  // log2 of the total clock divide
  function automatic logic [2:0] div_shift(input logic [1:0] div, input logic [1:0] src);
    return {1'b0, div} + {2'b00, (src == 2'b01)};
  endfunction

endpackage

// File: rtl/sarseq_clkdiv.sv
module sarseq_clkdiv #(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] shift,
  output logic       tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign lim  = ~({CNT_W{1'b1}} << shift);
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  // R1: any divide above one leaves a gap after each tick
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && shift != 3'd0) |=> !tick);

endmodule

// File: rtl/sarseq_timer.sv
module sarseq_timer import sarseq_pkg::*; #(
  parameter int OVH_CYC  = 6,
  parameter int BASE_CYC = 25,
  parameter int PH_W     = 5,
  parameter int IDX_W    = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  logic            tick,
  input  logic [PH_W-1:0] adder_len,
  input  logic [2:0]      avg_log2,
  output logic            busy,
  output logic            sample_ph,
  output logic            convert_ph,
  output logic            capture,
  output logic            final_cap
);
  localparam logic [PH_W-1:0] OVH_LAST  = PH_W'(OVH_CYC - 1);
  localparam logic [PH_W-1:0] BASE_LAST = PH_W'(BASE_CYC - 1);

  seq_state_t        state;
  logic [PH_W-1:0]   ph;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  idx_last;

  assign idx_last   = ~({IDX_W{1'b1}} << avg_log2);
  assign busy       = (state != ST_IDLE);
  assign sample_ph  = (state == ST_SMP);
  assign convert_ph = (state == ST_CNV);
  assign capture    = tick && (state == ST_CNV) && (ph == BASE_LAST);
  assign final_cap  = capture && (idx == idx_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ph    <= '0;
      idx   <= '0;
    end else if (launch) begin
      state <= ST_OVH;
      ph    <= '0;
      idx   <= '0;
    end else if (tick) begin
      case (state)
        ST_OVH: begin
          if (ph == OVH_LAST) begin state <= ST_SMP; ph <= '0; end
          else ph <= ph + 1'b1;
        end
        ST_SMP: begin
          if (ph == adder_len - 1'b1) begin state <= ST_CNV; ph <= '0; end
          else ph <= ph + 1'b1;
        end
        ST_CNV: begin
          if (ph == BASE_LAST) begin
            ph <= '0;
            if (idx == idx_last) state <= ST_IDLE;
            else begin idx <= idx + 1'b1; state <= ST_SMP; end
          end else ph <= ph + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sarseq_accum.sv
module sarseq_accum #(
  parameter int DATA_W = 12,
  parameter int ACC_W  = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              capture,
  input  logic              final_cap,
  input  logic [DATA_W-1:0] sample_in,
  input  logic [1:0]        res,
  input  logic [2:0]        avg_log2,
  output logic [DATA_W-1:0] result,
  output logic              done
);
  logic [DATA_W-1:0] mask;
  logic [ACC_W-1:0]  acc;
  logic [ACC_W-1:0]  sum;

  always_comb begin
    case (res)
      2'b00:   mask = {DATA_W{1'b1}} >> 4;
      2'b01:   mask = {DATA_W{1'b1}} >> 2;
      default: mask = {DATA_W{1'b1}};
    endcase
  end

  assign sum = acc + ACC_W'(sample_in & mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc    <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (launch) acc <= '0;
      else if (capture) begin
        if (final_cap) begin
          result <= DATA_W'(sum >> avg_log2);
          done   <= 1'b1;
        end else begin
          acc <= sum;
        end
      end
    end
  end

endmodule

// File: rtl/sar_conv_sequencer.sv
module sar_conv_sequencer import sarseq_pkg::*; #(
  parameter int DATA_W       = 12,
  parameter int OVH_CYC      = 6,
  parameter int BASE_CYC     = 25,
  parameter int AVG_LOG2_MAX = 5,
  parameter int DIV_LOG2_MAX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        cfg_clk_div,
  input  logic [1:0]        cfg_clk_src,
  input  logic              cfg_long_smp,
  input  logic [1:0]        cfg_smp_time,
  input  logic              cfg_avg_en,
  input  logic [1:0]        cfg_avg_num,
  input  logic [1:0]        cfg_res_mode,
  input  logic [DATA_W-1:0] adc_data,
  output logic              busy,
  output logic              sample_ph,
  output logic              convert_ph,
  output logic [DATA_W-1:0] result,
  output logic              done
);
  localparam int ACC_W = DATA_W + AVG_LOG2_MAX;
  localparam int IDX_W = AVG_LOG2_MAX;
  localparam int PRE_W = DIV_LOG2_MAX;
  localparam int PH_W  = $clog2(BASE_CYC + 1);

  seq_cfg_t        cfg_in, cfg_q;
  logic            launch, tick, capture, final_cap;
  logic [2:0]      div_sh, avg_sh;
  logic [PH_W-1:0] adder_len;

  always_comb begin
    cfg_in.div     = cfg_clk_div;
    cfg_in.src     = cfg_clk_src;
    cfg_in.long_en = cfg_long_smp;
    cfg_in.sts     = cfg_smp_time;
    cfg_in.avg_en  = cfg_avg_en;
    cfg_in.avg_num = cfg_avg_num;
    cfg_in.res     = cfg_res_mode;
  end

  assign launch = start && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (launch) cfg_q <= cfg_in;
  end

  assign div_sh    = div_shift(cfg_q.div, cfg_q.src);
  assign avg_sh    = avg_shift(cfg_q.avg_en, cfg_q.avg_num);
  assign adder_len = PH_W'(adder_cycles(cfg_q.long_en, cfg_q.sts));

  sarseq_clkdiv #(.CNT_W(PRE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .shift(div_sh), .tick(tick)
  );

  sarseq_timer #(.OVH_CYC(OVH_CYC), .BASE_CYC(BASE_CYC), .PH_W(PH_W), .IDX_W(IDX_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .launch(launch), .tick(tick),
    .adder_len(adder_len), .avg_log2(avg_sh),
    .busy(busy), .sample_ph(sample_ph), .convert_ph(convert_ph),
    .capture(capture), .final_cap(final_cap)
  );

  sarseq_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .launch(launch), .capture(capture),
    .final_cap(final_cap), .sample_in(adc_data), .res(cfg_q.res),
    .avg_log2(avg_sh), .result(result), .done(done)
  );

  // R2: completion is a single-cycle pulse
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: completion always follows a conversion window
  p_done_after_cnv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(convert_ph));

  // R8: captured configuration is frozen while a conversion runs
  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg_q));

  // R6: 8-bit mode never publishes upper bits
  p_res_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cfg_q.res == 2'b00) |-> ((result >> (DATA_W - 4)) == '0));

endmodule

// File: tb/sar_conv_sequencer_test.sv
module sar_conv_sequencer_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, start = 1'b0;
  logic [1:0]  cfg_clk_div = '0, cfg_clk_src = '0, cfg_smp_time = '0, cfg_avg_num = '0, cfg_res_mode = 2'b10;
  logic        cfg_long_smp = 1'b0, cfg_avg_en = 1'b0;
  logic [11:0] adc_data = '0;
  logic        busy, sample_ph, convert_ph, done;
  logic [11:0] result;

  sar_conv_sequencer uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_clk_div(cfg_clk_div), .cfg_clk_src(cfg_clk_src), .cfg_long_smp(cfg_long_smp),
    .cfg_smp_time(cfg_smp_time), .cfg_avg_en(cfg_avg_en), .cfg_avg_num(cfg_avg_num),
    .cfg_res_mode(cfg_res_mode), .adc_data(adc_data),
    .busy(busy), .sample_ph(sample_ph), .convert_ph(convert_ph), .result(result), .done(done)
  );

  int n_tests = 0, n_fail = 0;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // converter stub: pseudo-random words, or a fixed word
  bit          fix_en = 1'b0;
  logic [11:0] fix_val = '0;
  int unsigned seed = 32'h1234_5678;
  always @(negedge clk) begin
    seed = seed * 32'd1664525 + 32'd1013904223;
    adc_data = fix_en ? fix_val : seed[27:16];
  end

  // behavioural reference, advanced on each rising edge
  bit m_act = 0, m_done = 0;
  int m_e, m_D, m_L, m_P, m_T, m_nlog, m_mask, m_acc, m_res = 0, m_m;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_done = 0; m_res = 0;
    end else begin
      m_done = 0;
      if (m_act) begin
        m_e++;
        if (m_e % m_D == 0) begin
          m_m = m_e / m_D;
          if (m_m > 6 && ((m_m - 6) % m_P) == 0) m_acc += int'(adc_data) & m_mask;
          if (m_m == m_T) begin
            m_act = 0; m_done = 1; m_res = m_acc >> m_nlog;
          end
        end
      end else if (start) begin
        m_act  = 1; m_e = 0; m_acc = 0;
        m_D    = (1 << cfg_clk_div) * ((cfg_clk_src == 2'b01) ? 2 : 1);
        m_L    = cfg_long_smp ? 13 + 4 * int'(cfg_smp_time) : 3 + 2 * int'(cfg_smp_time);
        m_nlog = cfg_avg_en ? 2 + int'(cfg_avg_num) : 0;
        m_P    = 25 + m_L;
        m_T    = 6 + (1 << m_nlog) * m_P;
        m_mask = (cfg_res_mode == 2'b00) ? 255 : (cfg_res_mode == 2'b01) ? 1023 : 4095;
      end
    end
  end

  // per-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      int mm;
      bit es, ec;
      es = 0; ec = 0;
      if (m_act) begin
        mm = m_e / m_D;
        if (mm >= 6) begin
          es = ((mm - 6) % m_P) < m_L;
          ec = !es;
        end
      end
      check(busy == m_act, "R2", "busy", int'(busy), int'(m_act));
      check(done == m_done, "R2", "done", int'(done), int'(m_done));
      check(sample_ph == es, "R5", "sample_ph", int'(sample_ph), int'(es));
      check(convert_ph == ec, "R5", "convert_ph", int'(convert_ph), int'(ec));
      check(int'(result) == m_res, "R7", "result", int'(result), m_res);
    end
  end

  task automatic set_cfg(input logic [1:0] dv, input logic [1:0] sr, input logic lg, input logic [1:0] st,
                         input logic ae, input logic [1:0] an, input logic [1:0] rs);
    cfg_clk_div = dv; cfg_clk_src = sr; cfg_long_smp = lg; cfg_smp_time = st;
    cfg_avg_en = ae; cfg_avg_num = an; cfg_res_mode = rs;
  endtask

  task automatic run_conv(input logic [1:0] dv, input logic [1:0] sr, input logic lg, input logic [1:0] st,
                          input logic ae, input logic [1:0] an, input logic [1:0] rs, input string tag);
    int d, l, n, t, cnt;
    @(negedge clk);
    set_cfg(dv, sr, lg, st, ae, an, rs);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!done && cnt < 40000) begin @(negedge clk); cnt++; end
    d = (1 << dv) * ((sr == 2'b01) ? 2 : 1);
    l = lg ? 13 + 4 * int'(st) : 3 + 2 * int'(st);
    n = ae ? (4 << an) : 1;
    t = 6 + n * (25 + l);
    check(cnt == t * d, tag, "cycles start to done", cnt, t * d);
    @(negedge clk);
    check(done == 1'b0, "R2", "done pulse width", int'(done), 0);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", wd);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(busy == 0 && done == 0, "R9", "busy/done after reset", int'({busy, done}), 0);
    check(sample_ph == 0 && convert_ph == 0, "R9", "phases after reset", int'({sample_ph, convert_ph}), 0);
    check(result == 0, "R9", "result after reset", int'(result), 0);

    // R1 R2 R3: divide 1 with a non-divide source code, shortest window
    run_conv(2'd0, 2'b10, 1'b0, 2'd0, 1'b0, 2'd0, 2'b10, "R1 R2 R3");
    // R1 R3 R6: divide 2, L=9, 10-bit
    run_conv(2'd1, 2'b00, 1'b0, 2'd3, 1'b0, 2'd0, 2'b01, "R1 R3 R6");
    // R1 R3 R4: source adds divide, long L=17, N=4, 8-bit
    run_conv(2'd0, 2'b01, 1'b1, 2'd1, 1'b1, 2'd0, 2'b00, "R1 R3 R4");
    // R3 R4: L=7, N=8, mode 11 as 12-bit, divide 4
    run_conv(2'd2, 2'b00, 1'b0, 2'd2, 1'b1, 2'd1, 2'b11, "R3 R4 R6");
    // R3 R4: L=21, N=16
    run_conv(2'd0, 2'b00, 1'b1, 2'd2, 1'b1, 2'd2, 2'b10, "R3 R4");
    // R1 R3 R4: total divide 16, L=25, N=32
    run_conv(2'd3, 2'b01, 1'b1, 2'd3, 1'b1, 2'd3, 2'b10, "R1 R3 R4");

    // R7: constant word averaged over 4 gives the word itself
    fix_en = 1'b1; fix_val = 12'hABC;
    run_conv(2'd0, 2'b00, 1'b0, 2'd0, 1'b1, 2'd0, 2'b10, "R4 R7");
    check(result == 12'hABC, "R7", "mean of constant word", int'(result), 12'hABC);
    // R6: 8-bit mode keeps only the low byte
    run_conv(2'd0, 2'b00, 1'b0, 2'd0, 1'b0, 2'd0, 2'b00, "R6");
    check(result == 12'h0BC, "R6", "8-bit masked result", int'(result), 12'h0BC);
    // R7: result holds after done
    repeat (5) @(negedge clk);
    check(result == 12'h0BC, "R7", "result held", int'(result), 12'h0BC);

    // R8: config rewritten and start re-pulsed mid-conversion
    fix_val = 12'h923;
    @(negedge clk);
    set_cfg(2'd0, 2'b00, 1'b0, 2'd0, 1'b0, 2'd0, 2'b10);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    repeat (10) begin @(negedge clk); cnt++; end
    set_cfg(2'd3, 2'b01, 1'b1, 2'd3, 1'b1, 2'd3, 2'b00);
    start = 1'b1;
    @(negedge clk); cnt++;
    start = 1'b0;
    while (!done && cnt < 40000) begin @(negedge clk); cnt++; end
    check(cnt == 34, "R8", "length unaffected by mid-run change", cnt, 34);
    check(result == 12'h923, "R8", "resolution unaffected by mid-run change", int'(result), 12'h923);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R8", "start during busy not remembered", int'(busy), 0);

    fix_en = 1'b0;
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule